// File: doc/BRIEF.md
# Receive Signaling Freeze Controller

This block sits behind the framer of a T1 receiver and delays the per-channel signaling bits. Each channel's signaling nibble is written into a ring of multiframe slots, one slot for each received multiframe. The ring is read from the slot written the longest time ago, so what a channel presents at the output was received three multiframes earlier.

When the receive path is corrupted, the output is held at the last good values. Three alarm pulses can start this hold: frame sync lost, carrier lost, and frame slip. It can also be forced through a control register. The hold ends only after a full guard interval free of new alarms. The guard is counted in multiframes, which gives at least 9 ms with extended-superframe framing and at least 4.5 ms with twelve-frame (D4) framing.

A frame-layer controller drives the multiframe boundary strobe and the nibble writes. Software sets the enable and force bits through a small write port. Downstream reinsertion logic consumes the flat output vector and the freeze flag.

Top module: `sig_freeze_ctrl`

## Requirements
- R1: After reset, `sig_out` is all zeros, `sig_frozen` is 0, and both control bits are 0, so alarms have no effect.
- R2: A nibble written for channel c while multiframe n is current appears on `sig_out[4c+3:4c]` when the output is not frozen. It appears one clock after the `mf_start` that opens multiframe n+3 and stays until one clock after the `mf_start` that opens n+4. A write in the same cycle as `mf_start` belongs to the multiframe that strobe opens.
- R3: Nibble bit 3 is signaling bit A, bit 2 is B, bit 1 is C and bit 0 is D. With `esf_mode`=0 (D4), bits 1:0 are stored as zero and are presented as zero. With `esf_mode`=1, all four bits pass.
- R4: The control register is written only when `cfg_we`=1 and `cfg_addr`=0x40. Bit 4 is the freeze enable and bit 3 is the force bit. Writes to any other address change nothing.
- R5: When the enable bit is 1, a pulse on `oof_evt`, `los_evt` or `slip_evt` sets `sig_frozen` on the next clock. When the enable bit is 0, these pulses have no effect.
- R6: With the force bit at 1, `sig_frozen` is 1 from the clock after the write, whatever the enable bit holds. Clearing the force bit drops the flag on the next clock, unless an automatic freeze is still running.
- R7: `sig_out` is a register. It loads the buffer output on every clock where `sig_frozen` is 0 and holds on every clock where it is 1. The held value is therefore the good output present just before the freeze began.
- R8: An automatic freeze is released by the 4th `mf_start` after the most recent alarm, so that at least 3 full multiframes pass. The flag clears one clock after that strobe. An alarm arriving in the same cycle as `mf_start` restarts the count.
- R9: Clearing the enable bit cancels a running automatic freeze, and the flag falls within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mf_start | input | 1 | One-cycle strobe marking the first cycle of a multiframe |
| sig_we | input | 1 | Signaling nibble write strobe |
| sig_chan | input | 5 | Channel index of the write (0..23) |
| sig_nib | input | 4 | Signaling nibble, A in bit 3 down to D in bit 0 |
| esf_mode | input | 1 | 1 = extended superframe, 0 = D4 framing |
| oof_evt | input | 1 | Frame sync loss pulse |
| los_evt | input | 1 | Carrier loss pulse |
| slip_evt | input | 1 | Frame slip pulse |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 8 | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| sig_out | output | 96 | Delayed or frozen signaling, channel c in bits 4c+3:4c |
| sig_frozen | output | 1 | Freeze in effect |

## Verification
There are two collisions of interest. In the first, an alarm and a multiframe boundary arrive in the same cycle while the output is live. The alarm is pulsed together with `mf_start`, and the bench expects the held output to be the pre-boundary multiframe's data rather than the newly exposed slot. In the second, an alarm lands on a boundary while a release count is running. The bench pulses a slip with the strobe two multiframes into a hold. It then expects the flag to stay set for three further boundaries and to fall only on the fourth.

// File: rtl/sfz_pkg.sv
package sfz_pkg;
   localparam int SIG_W       = 4;
   localparam int CFG_EN_BIT  = 4;
   localparam int CFG_FRC_BIT = 3;
   localparam logic [SIG_W-1:0] MASK_D4  = 4'b1100;
   localparam logic [SIG_W-1:0] MASK_ESF = 4'b1111;

   typedef struct packed {
      logic en;
      logic frc;
   } sfz_cfg_t;
endpackage

// File: rtl/sfz_cfg_reg.sv
module sfz_cfg_reg
   import sfz_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output sfz_cfg_t          cfg
);
   localparam logic [DATA_W-1:0] KEEP =
      (DATA_W'(1) << CFG_EN_BIT) | (DATA_W'(1) << CFG_FRC_BIT);

   if (DATA_W <= CFG_EN_BIT) begin : g_bad_w
      $error("sfz_cfg_reg: DATA_W too narrow for control bits");
   end

   logic hit;
   assign hit = we && (addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (hit) begin
         cfg.en  <= wdata[CFG_EN_BIT];
         cfg.frc <= wdata[CFG_FRC_BIT];
      end
   end

   AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr != CFG_ADDR) |=> $stable(cfg)) else $error("other address wrote cfg"); // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((wdata & ~KEEP) == '0)) else $error("reserved bits written nonzero"); // R4
endmodule

// File: rtl/sfz_hold_timer.sv
module sfz_hold_timer #(
   parameter  int HOLD_MF = 3,
   localparam int LOAD    = HOLD_MF + 1,
   localparam int CW      = $clog2(LOAD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic evt,
   input  logic mf_start,
   output logic active
);
   if (HOLD_MF < 1) begin : g_bad_hold
      $error("sfz_hold_timer: HOLD_MF must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (evt) begin
         cnt <= CW'(LOAD);
      end else if (mf_start && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign active = (cnt != '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LOAD)) else $error("hold count overflow"); // R8
   AST_REL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(mf_start) || !$past(en))) else $error("release off boundary"); // R8
   AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !active) else $error("auto freeze while disabled"); // R9
endmodule

// File: rtl/sfz_sig_buffer.sv
module sfz_sig_buffer
   import sfz_pkg::*;
#(
   parameter  int NCH   = 24,
   parameter  int DEPTH = 4,
   localparam int CHW   = $clog2(NCH),
   localparam int PW    = $clog2(DEPTH),
   localparam int OW    = NCH * SIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mf_start,
   input  logic             we,
   input  logic [CHW-1:0]   chan,
   input  logic [SIG_W-1:0] nib,
   input  logic             esf_mode,
   output logic [OW-1:0]    live
);
   if (NCH < 2) begin : g_bad_nch
      $error("sfz_sig_buffer: NCH must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("sfz_sig_buffer: DEPTH must be at least 2");
   end

   logic [SIG_W-1:0] mem [DEPTH][NCH];
   logic [PW-1:0]    wp, wp_nxt, wp_eff, rd;
   logic [SIG_W-1:0] msk, nib_m;

   assign wp_nxt = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
   assign wp_eff = mf_start ? wp_nxt : wp;
   assign rd     = wp_nxt;
   assign msk    = esf_mode ? MASK_ESF : MASK_D4;
   assign nib_m  = nib & msk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         for (int s = 0; s < DEPTH; s++)
            for (int c = 0; c < NCH; c++)
               mem[s][c] <= '0;
      end else begin
         if (mf_start) wp <= wp_nxt;
         if (we && (32'(chan) < NCH)) mem[wp_eff][chan] <= nib_m;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign live[c*SIG_W +: SIG_W] = mem[rd][c] & msk;
   end
endmodule

// File: rtl/sig_freeze_ctrl.sv
module sig_freeze_ctrl
   import sfz_pkg::*;
#(
   parameter  int                NCH      = 24,
   parameter  int                DEPTH    = 4,
   parameter  int                HOLD_MF  = 3,
   parameter  int                ADDR_W   = 8,
   parameter  int                DATA_W   = 8,
   parameter  logic [ADDR_W-1:0] CFG_ADDR = 8'h40,
   localparam int                CHW      = $clog2(NCH),
   localparam int                OW       = NCH * SIG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mf_start,
   input  logic              sig_we,
   input  logic [CHW-1:0]    sig_chan,
   input  logic [SIG_W-1:0]  sig_nib,
   input  logic              esf_mode,
   input  logic              oof_evt,
   input  logic              los_evt,
   input  logic              slip_evt,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [OW-1:0]     sig_out,
   output logic              sig_frozen
);
   sfz_cfg_t      cfg;
   logic          any_evt, auto_act;
   logic [OW-1:0] live;

   assign any_evt = oof_evt | los_evt | slip_evt;

   sfz_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .cfg(cfg)
   );

   sfz_hold_timer #(.HOLD_MF(HOLD_MF)) tmr_i (
      .clk(clk), .rst_n(rst_n), .en(cfg.en), .evt(any_evt),
      .mf_start(mf_start), .active(auto_act)
   );

   sfz_sig_buffer #(.NCH(NCH), .DEPTH(DEPTH)) buf_i (
      .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .we(sig_we), .chan(sig_chan),
      .nib(sig_nib), .esf_mode(esf_mode), .live(live)
   );

   assign sig_frozen = cfg.frc | auto_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sig_out <= '0;
      else if (!sig_frozen) sig_out <= live;
   end

   AST_EVT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && any_evt) |=> sig_frozen) else $error("alarm did not freeze"); // R5
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sig_frozen) |-> $stable(sig_out)) else $error("output moved while frozen"); // R7
endmodule

// File: tb/sig_freeze_ctrl_tb_top.sv
module sig_freeze_ctrl_tb_top;
   localparam int NCH = 24;
   localparam int W   = NCH * 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mf_start = 1'b0, sig_we = 1'b0, esf_mode = 1'b1;
   logic [4:0]   sig_chan = '0;
   logic [3:0]   sig_nib = '0;
   logic         oof_evt = 1'b0, los_evt = 1'b0, slip_evt = 1'b0;
   logic         cfg_we = 1'b0;
   logic [7:0]   cfg_addr = '0, cfg_wdata = '0;
   logic [W-1:0] sig_out;
   logic         sig_frozen;

   int n_run = 0, n_fail = 0, cyc = 0, cur = 0;
   bit mode_hist [0:127];
   logic [W-1:0] frz;

   always #2.5 clk = ~clk;

   sig_freeze_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .sig_we(sig_we), .sig_chan(sig_chan),
      .sig_nib(sig_nib), .esf_mode(esf_mode), .oof_evt(oof_evt), .los_evt(los_evt),
      .slip_evt(slip_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sig_out(sig_out), .sig_frozen(sig_frozen)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   function automatic logic [3:0] fexp(int n, int c);
      return 4'((n * 7 + c * 3 + 5) % 16);
   endfunction

   function automatic logic [W-1:0] expv(int k);
      logic [W-1:0] v = '0;
      if (k >= 3)
         for (int c = 0; c < NCH; c++)
            v[c*4 +: 4] = fexp(k - 3, c) & (mode_hist[k-3] ? 4'hF : 4'hC) & (esf_mode ? 4'hF : 4'hC);
      return v;
   endfunction

   task automatic chk_vec(string req, logic [W-1:0] e);
      n_run++;
      if (sig_out !== e) begin
         n_fail++;
         $display("FAIL %s sig_out actual %h expected %h", req, sig_out, e);
      end
   endtask

   task automatic chk_flag(string req, logic e);
      n_run++;
      if (sig_frozen !== e) begin
         n_fail++;
         $display("FAIL %s sig_frozen actual %b expected %b", req, sig_frozen, e);
      end
   endtask

   task automatic fill();
      mode_hist[cur] = esf_mode;
      for (int c = 0; c < NCH; c++) begin
         @(negedge clk);
         sig_we = 1'b1; sig_chan = 5'(c); sig_nib = fexp(cur, c);
      end
      @(negedge clk);
      sig_we = 1'b0;
   endtask

   task automatic step(bit o, bit l, bit s);
      fill();
      mf_start = 1'b1; oof_evt = o; los_evt = l; slip_evt = s;
      @(negedge clk);
      mf_start = 1'b0; oof_evt = 1'b0; los_evt = 1'b0; slip_evt = 1'b0;
      @(negedge clk);
      cur++;
   endtask

   task automatic pulse(bit o, bit l, bit s);
      oof_evt = o; los_evt = l; slip_evt = s;
      @(negedge clk);
      oof_evt = 1'b0; los_evt = 1'b0; slip_evt = 1'b0;
   endtask

   task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_vec("R1 reset output", '0);
      chk_flag("R1 reset flag", 1'b0);

      // R2 delay sweep in ESF
      esf_mode = 1'b1;
      for (int i = 0; i < 8; i++) begin
         step(0, 0, 0);
         chk_vec("R2 esf delay", expv(cur));
         chk_flag("R2 no freeze", 1'b0);
      end
      // R3 D4 masking sweep
      esf_mode = 1'b0;
      for (int i = 0; i < 8; i++) begin
         step(0, 0, 0);
         chk_vec("R3 d4 mask", expv(cur));
      end
      esf_mode = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step(0, 0, 0);
         chk_vec("R3 back to esf", expv(cur));
      end

      // R5 disabled: alarm ignored (also R1 enable reset to 0)
      pulse(1, 0, 0);
      chk_flag("R5 disabled alarm", 1'b0);
      @(negedge clk);
      chk_vec("R5 output live", expv(cur));

      // R4 wrong address ignored
      cfg_wr(8'h41, 8'h18);
      chk_flag("R4 wrong addr force", 1'b0);
      pulse(0, 1, 0);
      chk_flag("R4 wrong addr enable", 1'b0);
      step(0, 0, 0);
      chk_vec("R4 output live", expv(cur));

      // R5 R7 R8 alarm mid-multiframe then release
      cfg_wr(8'h40, 8'h10);
      frz = expv(cur);
      pulse(1, 0, 0);
      chk_flag("R5 oof freeze", 1'b1);
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 0);
         chk_flag("R8 hold", 1'b1);
         chk_vec("R7 held value", frz);
      end
      step(0, 0, 0);
      chk_flag("R8 release", 1'b0);
      chk_vec("R8 resumed output", expv(cur));

      // alarm on a boundary while live: capture pre-boundary data
      frz = expv(cur);
      step(0, 1, 0);
      chk_flag("R5 los on boundary", 1'b1);
      chk_vec("R7 pre-boundary capture", frz);
      step(0, 0, 0);
      step(0, 0, 0);
      step(0, 0, 1);
      chk_flag("R8 slip restarts", 1'b1);
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 0);
         chk_flag("R8 restarted hold", 1'b1);
         chk_vec("R7 held after restart", frz);
      end
      step(0, 0, 0);
      chk_flag("R8 release after restart", 1'b0);
      chk_vec("R8 resumed after restart", expv(cur));

      // R9 disable cancels freeze
      pulse(0, 1, 0);
      chk_flag("R9 frozen before disable", 1'b1);
      cfg_wr(8'h40, 8'h00);
      @(negedge clk);
      chk_flag("R9 disable cancels", 1'b0);
      @(negedge clk);
      chk_vec("R9 output live", expv(cur));

      // R6 force with enable 0
      frz = expv(cur);
      cfg_wr(8'h40, 8'h08);
      chk_flag("R6 force", 1'b1);
      for (int i = 0; i < 2; i++) begin
         step(0, 0, 0);
         chk_flag("R6 force held", 1'b1);
         chk_vec("R6 forced value", frz);
      end
      cfg_wr(8'h40, 8'h00);
      chk_flag("R6 force cleared", 1'b0);
      @(negedge clk);
      chk_vec("R6 output live", expv(cur));

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule